// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single output line. A processor-side write strobe places a character into a one-entry holding buffer. At the next bit boundary where the line is idle, or where a stop bit is ending, the character moves into a shift register. The shift register then sends a low start bit, the data bits least significant first, and a high stop bit. Because the buffer can be refilled while a character is still on the wire, frames can follow each other with no idle gap.

Characters can be five to nine bits long. The ninth bit comes from a separate one-bit register that software writes before the low byte. The data write captures that bit together with the byte, so a later change to the register does not affect a character that is already buffered. Bit timing has two stages. A programmable clock divider produces ticks, and a bit lasts sixteen of those ticks, or eight when double speed is selected.

The enable input decides whether the transmitter drives the line. Clearing the enable does not cut a character short. The transmitter keeps ownership until the buffer and the shift register are both empty, and only then releases the line to its idle-high value.

Top module: `ser_tx9`

## Requirements
- R1: After reset, `txd` is 1, `tx_own` is 0, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is one low start bit, then the data bits least significant first, then one high stop bit. The line is high whenever no frame is being sent.
- R3: The character length comes from `char_sel`, sampled when a character enters the shift register. The codes are: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8, 4 gives 9, and 5 to 7 give 8.
- R4: In 9-bit mode, the last data bit is the value that `ninth_bit` held in the ninth-bit register at the moment of the data write. Writing the register after the data write does not change the buffered character.
- R5: One bit lasts (`baud_div`+1)×16 clock cycles when `dbl_speed` is 0, and (`baud_div`+1)×8 clock cycles when `dbl_speed` is 1.
- R6: A character written while another is being sent starts exactly at the end of the previous stop bit. Frame starts are therefore (bits+2) bit periods apart.
- R7: `buf_empty` falls on the cycle after an accepted write and rises when the character moves into the shift register. A data write while the buffer is full is ignored.
- R8: `tx_done` is a one-cycle pulse when a stop bit ends and no character is waiting. It does not pulse between back-to-back frames.
- R9: Clearing `tx_en` lets the character in the shift register and any buffered character finish. `tx_own` then falls, and while `tx_own` is 0, `txd` is 1.
- R10: A data write while `tx_en` is 0 is ignored and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Clock divider: one tick every baud_div+1 cycles |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| char_sel | input | 3 | Character length code (see R3) |
| tx_en | input | 1 | Transmitter enable |
| ninth_wr | input | 1 | Write strobe for the ninth-bit register |
| ninth_bit | input | 1 | Value written to the ninth-bit register |
| data_wr | input | 1 | Write strobe for the low data byte |
| data_byte | input | 8 | Low data byte |
| txd | output | 1 | Serial output line |
| tx_own | output | 1 | 1 while the transmitter drives the line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Pulse: last frame finished with nothing waiting |

## Verification
A receiver model in the bench decodes the line by sampling at the middle of each bit. Single random frames across all length codes, both speed settings and several divider values check the bit order, the length decoding and the bit period. Back-to-back pairs at two speeds tell a gapless handover apart from one that inserts an idle bit, by measuring the exact spacing between frame starts. Directed sequences cover the ninth bit captured at the data write, a write to a full buffer, a write while disabled, and disabling in the middle of a frame. These separate deferred release of the line from early cutoff.

// File: rtl/ser_tx9_pkg.sv
package ser_tx9_pkg;

    localparam int CHAR_MAX = 9;
    localparam int LEFT_W   = $clog2(CHAR_MAX + 1);

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_st_e;

    // Length code to number of data bits.
    function automatic logic [LEFT_W-1:0] char_bits(input logic [2:0] sel);
        case (sel)
            3'd0:    char_bits = LEFT_W'(5);
            3'd1:    char_bits = LEFT_W'(6);
            3'd2:    char_bits = LEFT_W'(7);
            3'd4:    char_bits = LEFT_W'(9);
            default: char_bits = LEFT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/ser_tx9_tick.sv
module ser_tx9_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_s;

    tick_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt >= div);
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0)) else $error("tick counter did not restart"); // R5

endmodule

// File: rtl/ser_tx9_bitclk.sv
module ser_tx9_bitclk (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic dbl,
    output logic bit_end
);

    localparam int PH_W = 4;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_s;

    ph_s st_d, st_q;
    logic [PH_W-1:0] last;

    always_comb begin
        st_d    = st_q;
        last    = dbl ? PH_W'(7) : PH_W'(15);
        bit_end = run && tick && (st_q.phase >= last);
        if (!run) begin
            st_d.phase = '0;
        end else if (tick) begin
            st_d.phase = bit_end ? '0 : st_q.phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PHASE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(st_q.phase)) else $error("phase moved without tick"); // R5

endmodule

// File: rtl/ser_tx9_core.sv
module ser_tx9_core
    import ser_tx9_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       bit_end,
    input  logic [2:0] char_sel,
    input  logic       ninth_wr,
    input  logic       ninth_bit,
    input  logic       data_wr,
    input  logic [7:0] data_byte,
    output logic       line,
    output logic       own,
    output logic       buf_empty,
    output logic       done
);

    typedef struct packed {
        line_st_e            st;
        logic [CHAR_MAX-1:0] sreg;
        logic [LEFT_W-1:0]   left;
        logic [CHAR_MAX-1:0] hold;
        logic                full;
        logic                ninth;
        logic                own;
        logic                done;
    } core_s;

    core_s st_d, st_q;
    logic  accept;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = data_wr && tx_en && !st_q.full;

        if (ninth_wr) begin
            st_d.ninth = ninth_bit;
        end

        if (bit_end) begin
            case (st_q.st)
                LN_IDLE, LN_STOP: begin
                    if (st_q.full) begin
                        st_d.st   = LN_START;
                        st_d.sreg = st_q.hold;
                        st_d.left = char_bits(char_sel);
                        st_d.full = 1'b0;
                    end else if (st_q.st == LN_STOP) begin
                        st_d.st   = LN_IDLE;
                        st_d.done = 1'b1;
                    end
                end
                LN_START: begin
                    st_d.st = LN_DATA;
                end
                default: begin
                    st_d.sreg = st_q.sreg >> 1;
                    st_d.left = st_q.left - LEFT_W'(1);
                    if (st_q.left == LEFT_W'(1)) begin
                        st_d.st = LN_STOP;
                    end
                end
            endcase
        end

        if (accept) begin
            st_d.hold = {st_q.ninth, data_byte};
            st_d.full = 1'b1;
        end

        st_d.own = tx_en || (st_q.own && !(st_q.st == LN_IDLE && !st_q.full));

        case (st_q.st)
            LN_START: line = 1'b0;
            LN_DATA:  line = st_q.sreg[0];
            default:  line = 1'b1;
        endcase

        own       = st_q.own;
        buf_empty = !st_q.full;
        done      = st_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= LN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_end |=> $stable(line)) else $error("line changed off a bit boundary"); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !bit_end) |=> (st_q.full && $stable(st_q.hold))) else $error("buffer overwritten"); // R7

    AST_OWN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && st_q.st != LN_IDLE) |=> st_q.own) else $error("released mid frame"); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.st == LN_IDLE)) else $error("done while busy"); // R8

endmodule

// File: rtl/ser_tx9.sv
module ser_tx9 #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             dbl_speed,
    input  logic [2:0]       char_sel,
    input  logic             tx_en,
    input  logic             ninth_wr,
    input  logic             ninth_bit,
    input  logic             data_wr,
    input  logic [7:0]       data_byte,
    output logic             txd,
    output logic             tx_own,
    output logic             buf_empty,
    output logic             tx_done
);

    logic tick;
    logic bit_end;
    logic line;

    ser_tx9_tick #(.DIV_W(DIV_W)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (tick)
    );

    ser_tx9_bitclk i_bitclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tx_own),
        .tick   (tick),
        .dbl    (dbl_speed),
        .bit_end(bit_end)
    );

    ser_tx9_core i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .bit_end  (bit_end),
        .char_sel (char_sel),
        .ninth_wr (ninth_wr),
        .ninth_bit(ninth_bit),
        .data_wr  (data_wr),
        .data_byte(data_byte),
        .line     (line),
        .own      (tx_own),
        .buf_empty(buf_empty),
        .done     (tx_done)
    );

    assign txd = tx_own ? line : 1'b1;

    AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_own |-> txd) else $error("line low while released"); // R9

endmodule

// File: tb/test_ser_tx9.sv
module test_ser_tx9;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] baud_div = '0;
    logic             dbl_speed = 1'b0;
    logic [2:0]       char_sel = 3'd3;
    logic             tx_en = 1'b0;
    logic             ninth_wr = 1'b0;
    logic             ninth_bit = 1'b0;
    logic             data_wr = 1'b0;
    logic [7:0]       data_byte = '0;
    logic             txd, tx_own, buf_empty, tx_done;

    always #2 clk = ~clk;

    ser_tx9 #(.DIV_W(DIV_W)) i_ser_tx9 (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .dbl_speed(dbl_speed),
        .char_sel(char_sel), .tx_en(tx_en), .ninth_wr(ninth_wr), .ninth_bit(ninth_bit),
        .data_wr(data_wr), .data_byte(data_byte), .txd(txd), .tx_own(tx_own),
        .buf_empty(buf_empty), .tx_done(tx_done)
    );

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int bitper_cfg = 16;
    int nbits_cfg = 8;
    logic [8:0] rx_val [0:127];
    int         rx_cyc [0:127];
    bit         rx_good[0:127];
    int rx_n = 0;
    int done_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && tx_done) done_cnt <= done_cnt + 1;

    function automatic int bits_of(input logic [2:0] sel);
        case (sel)
            3'd0: return 5;
            3'd1: return 6;
            3'd2: return 7;
            3'd4: return 9;
            default: return 8;
        endcase
    endfunction

    function automatic logic [8:0] exp_frame(input logic [7:0] b, input logic n9, input int nb);
        logic [8:0] m;
        m = 9'((1 << nb) - 1);
        return {n9, b} & m;
    endfunction

    // Receiver model: sample the middle of each bit.
    initial begin : rx_model
        logic prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd) begin : frame
                int st; int bp; int nb; logic [8:0] v; bit ok;
                st = cyc; bp = bitper_cfg; nb = nbits_cfg; v = '0; ok = 1'b1;
                repeat (bp / 2) @(negedge clk);
                if (txd !== 1'b0) ok = 1'b0;
                for (int i = 0; i < nb; i++) begin
                    repeat (bp) @(negedge clk);
                    v[i] = txd;
                end
                repeat (bp) @(negedge clk);
                if (txd !== 1'b1) ok = 1'b0;
                if (rx_n < 128) begin
                    rx_val[rx_n] = v; rx_cyc[rx_n] = st; rx_good[rx_n] = ok;
                end
                rx_n = rx_n + 1;
            end
            prev = txd;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int div, input bit dbl, input logic [2:0] sel);
        baud_div   = DIV_W'(div);
        dbl_speed  = dbl;
        char_sel   = sel;
        bitper_cfg = (div + 1) * (dbl ? 8 : 16);
        nbits_cfg  = bits_of(sel);
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); data_wr = 1'b1; data_byte = b;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic put_ninth(input logic b);
        @(negedge clk); ninth_wr = 1'b1; ninth_bit = b;
        @(negedge clk); ninth_wr = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        while (rx_n < n) @(negedge clk);
        repeat (bitper_cfg + 4) @(negedge clk);
    endtask

    task automatic wait_loaded();
        while (!buf_empty) @(negedge clk);
    endtask

    task automatic chk_frame(input string req, input int k, input logic [8:0] exp);
        chk(req, {22'd0, rx_good[k], rx_val[k]}, {22'd0, 1'b1, exp});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int base; int d0;
        logic [7:0] a; logic [7:0] b;
        void'($urandom(32'd20240607));
        cfg(0, 0, 3'd3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 tx_own", 32'(tx_own), 32'd0);
        chk("R1 buf_empty", 32'(buf_empty), 32'd1);
        chk("R1 tx_done", 32'(tx_done), 32'd0);

        // R10: write while disabled is dropped
        put_byte(8'hA5);
        chk("R10 buf_empty", 32'(buf_empty), 32'd1);
        tx_en = 1'b1;
        repeat (3 * bitper_cfg) @(negedge clk);
        chk("R10 no frame", 32'(rx_n), 32'd0);

        // R2 / R7 / R8: single 8-bit frame
        base = rx_n; d0 = done_cnt;
        put_byte(8'h5A);
        chk("R7 buf_empty after write", 32'(buf_empty), 32'd0);
        wait_rx(base + 1);
        chk_frame("R2 frame 5A", base, 9'h05A);
        chk("R8 done pulses", 32'(done_cnt - d0), 32'd1);

        // R4: ninth bit captured at data write
        cfg(1, 0, 3'd4);
        base = rx_n;
        put_ninth(1'b1);
        put_byte(8'h3C);
        put_ninth(1'b0);
        wait_rx(base + 1);
        chk_frame("R4 ninth captured", base, 9'h13C);
        base = rx_n;
        put_byte(8'hFF);
        wait_rx(base + 1);
        chk_frame("R4 ninth cleared", base, 9'h0FF);

        // R6 / R7 / R5: back-to-back, dbl on, extra write ignored
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 0) cfg(2, 1, 3'd3); else cfg(1, 0, 3'd0);
            base = rx_n; d0 = done_cnt;
            a = 8'($urandom); b = 8'($urandom);
            put_byte(a);
            wait_loaded();
            put_byte(b);
            put_byte(8'h81);
            wait_rx(base + 2);
            repeat (3 * bitper_cfg) @(negedge clk);
            chk_frame("R6 first", base, exp_frame(a, 1'b0, nbits_cfg));
            chk_frame("R7 second kept", base + 1, exp_frame(b, 1'b0, nbits_cfg));
            chk("R7 full write ignored", 32'(rx_n - base), 32'd2);
            chk("R6 R5 spacing", 32'(rx_cyc[base + 1] - rx_cyc[base]),
                32'((nbits_cfg + 2) * bitper_cfg));
            chk("R8 one done per burst", 32'(done_cnt - d0), 32'd1);
        end

        // R9: deferred disable
        cfg(0, 0, 3'd3);
        base = rx_n;
        put_byte(8'hC3);
        wait_loaded();
        put_byte(8'h3E);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R9 still owned", 32'(tx_own), 32'd1);
        wait_rx(base + 2);
        repeat (8) @(negedge clk);
        chk_frame("R9 frame a", base, 9'h0C3);
        chk_frame("R9 frame b", base + 1, 9'h03E);
        chk("R9 released", 32'(tx_own), 32'd0);
        chk("R9 idle high", 32'(txd), 32'd1);
        tx_en = 1'b1;

        // R3 / R5: random single frames
        for (int it = 0; it < 24; it++) begin : rnd
            logic [2:0] sel; logic n9; logic [7:0] dv;
            sel = 3'($urandom_range(0, 7));
            if (it < 8) sel = 3'(it);
            n9 = 1'($urandom); dv = 8'($urandom);
            cfg(int'($urandom_range(0, 3)), 1'($urandom), sel);
            base = rx_n; d0 = done_cnt;
            put_ninth(n9);
            put_byte(dv);
            wait_rx(base + 1);
            chk_frame("R3 random frame", base, exp_frame(dv, n9, nbits_cfg));
            chk("R8 random done", 32'(done_cnt - d0), 32'd1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule